// File: doc/BRIEF.md
# Three-Register Exchange Sequencer

This block exchanges the contents of two n-bit registers over a single shared data bus. It uses a third register as scratch storage. A small Moore controller runs three bus transfers in a fixed order. Each transfer enables exactly one register to drive the bus and exactly one register to load from it. The controller marks the last transfer with a completion flag.

The three registers sit inside the block. The shared bus is modelled as an AND-OR selector driven by the output enables. An external write port lets the surrounding logic (or a bench) preload any register. A swap is requested by raising a start input while the controller is idle. Once started, the sequence runs to the end without regard to the start input.

Register numbering used throughout: index 0 is the first register (A), index 1 is the second (B), index 2 is the scratch register (S). Bit k of every enable vector refers to register k.

Top module: `regswap_unit`

## Requirements
- R1: After reset the controller is idle, `drv_en_o` and `ld_en_o` are 3'b000, `done_o` is 0, and all three registers hold zero.
- R2: While idle and `start_i` is 0 at a rising edge, the controller stays idle: all enables and `done_o` stay 0.
- R3: A rising edge that sees `start_i`=1 while idle enters the save step for one cycle. In this step `drv_en_o`=3'b010 and `ld_en_o`=3'b100, so B is copied into S.
- R4: The save step is followed on the next edge by the move step for one cycle. In this step `drv_en_o`=3'b001 and `ld_en_o`=3'b010, so A is copied into B.
- R5: The move step is followed on the next edge by the restore step for one cycle. In this step `drv_en_o`=3'b100, `ld_en_o`=3'b001 and `done_o`=1, so S is copied into A. `done_o` is 0 in every other cycle.
- R6: The restore step returns to idle on the next edge whatever `start_i` is. With `start_i` held at 1, a new save step begins one idle cycle later.
- R7: After a complete sequence, A holds the old B, B holds the old A, and S holds the old B.
- R8: At most one bit of `drv_en_o` and at most one bit of `ld_en_o` is set in any cycle. Exactly one bit of each is set in every transfer step.
- R9: A `start_i` pulse raised during any transfer step neither lengthens nor restarts the sequence. The controller is idle after the restore step and stays idle while `start_i` is 0.
- R10: When `wr_en_i[k]`=1 at a rising edge, register k loads `wr_data_i`. Several registers may be written in the same edge.
- R11: When a register is loaded from the bus and from `wr_data_i` at the same edge, the bus value wins. External writes to the other registers still take effect.
- R12: `bus_o` carries the value of the register selected by `drv_en_o`, and is zero when no register drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Swap request, sampled only while idle |
| wr_en_i | input | 3 | Per-register external write enables |
| wr_data_i | input | DATA_W | External write data |
| drv_en_o | output | 3 | Bus drive enables (bit k = register k) |
| ld_en_o | output | 3 | Bus load enables (bit k = register k) |
| done_o | output | 1 | High during the final transfer |
| bus_o | output | DATA_W | Shared bus value |
| reg_a_o | output | DATA_W | Contents of register A |
| reg_b_o | output | DATA_W | Contents of register B |
| reg_s_o | output | DATA_W | Contents of scratch register S |

## Verification
The hardest case to reach is a bus load and an external write landing on the same register at the same edge. That window is only one cycle wide, in the middle of a swap. The bench reaches it by counting edges from the start pulse. It raises the write enable for the scratch register, plus one other register, exactly during the save step. It then checks that the scratch register took the bus value while the other write landed. The retrigger case is reached the same way: a start pulse placed inside the move step, followed by idle cycles that must stay idle.

// File: rtl/regswap_pkg.sv
package regswap_pkg;

   localparam int unsigned NUM_REGS = 3;
   localparam int unsigned IDX_A    = 0;
   localparam int unsigned IDX_B    = 1;
   localparam int unsigned IDX_S    = 2;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SAVE    = 2'd1,
      ST_MOVE    = 2'd2,
      ST_RESTORE = 2'd3
   } swap_state_e;

   typedef logic [NUM_REGS-1:0] reg_sel_t;

   function automatic reg_sel_t sel_of(input int unsigned idx);
      reg_sel_t s;
      s = '0;
      s[idx] = 1'b1;
      return s;
   endfunction

endpackage

// File: rtl/regswap_fsm.sv
module regswap_fsm
   import regswap_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   output reg_sel_t drv_en_o,
   output reg_sel_t ld_en_o,
   output logic     done_o
);

   swap_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start_i) state_d = ST_SAVE;
         ST_SAVE:    state_d = ST_MOVE;
         ST_MOVE:    state_d = ST_RESTORE;
         ST_RESTORE: state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // Moore decode: outputs depend only on the current step
   always_comb begin
      drv_en_o = '0;
      ld_en_o  = '0;
      done_o   = 1'b0;
      unique case (state_q)
         ST_SAVE: begin
            drv_en_o = sel_of(IDX_B);
            ld_en_o  = sel_of(IDX_S);
         end
         ST_MOVE: begin
            drv_en_o = sel_of(IDX_A);
            ld_en_o  = sel_of(IDX_B);
         end
         ST_RESTORE: begin
            drv_en_o = sel_of(IDX_S);
            ld_en_o  = sel_of(IDX_A);
            done_o   = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/regswap_bus.sv
module regswap_bus #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SRCS   = 3
) (
   input  logic [SRCS-1:0]             drv_en_i,
   input  logic [SRCS-1:0][DATA_W-1:0] src_i,
   output logic [DATA_W-1:0]           bus_o
);

   // AND-OR model of a shared tri-state bus; idle bus reads as zero
   always_comb begin
      bus_o = '0;
      for (int k = 0; k < SRCS; k++) begin
         bus_o = bus_o | (src_i[k] & {DATA_W{drv_en_i[k]}});
      end
   end

endmodule

// File: rtl/regswap_reg.sv
module regswap_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ld_i,
   input  logic [DATA_W-1:0] bus_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o <= '0;
      else if (bus_ld_i) q_o <= bus_i;
      else if (wr_en_i)  q_o <= wr_data_i;
   end

endmodule

// File: rtl/regswap_unit.sv
module regswap_unit
   import regswap_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [2:0]        drv_en_o,
   output logic [2:0]        ld_en_o,
   output logic              done_o,
   output logic [DATA_W-1:0] bus_o,
   output logic [DATA_W-1:0] reg_a_o,
   output logic [DATA_W-1:0] reg_b_o,
   output logic [DATA_W-1:0] reg_s_o
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("regswap_unit: DATA_W must be at least 1");
      end
   endgenerate

   reg_sel_t                           drv_en;
   reg_sel_t                           ld_en;
   logic [NUM_REGS-1:0][DATA_W-1:0]    regs_q;
   logic [DATA_W-1:0]                  bus;

   regswap_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .drv_en_o (drv_en),
      .ld_en_o  (ld_en),
      .done_o   (done_o)
   );

   regswap_bus #(.DATA_W(DATA_W), .SRCS(NUM_REGS)) u_bus (
      .drv_en_i (drv_en),
      .src_i    (regs_q),
      .bus_o    (bus)
   );

   generate
      for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
         regswap_reg #(.DATA_W(DATA_W)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_ld_i  (ld_en[k]),
            .bus_i     (bus),
            .wr_en_i   (wr_en_i[k]),
            .wr_data_i (wr_data_i),
            .q_o       (regs_q[k])
         );
      end
   endgenerate

   assign drv_en_o = drv_en;
   assign ld_en_o  = ld_en;
   assign bus_o    = bus;
   assign reg_a_o  = regs_q[IDX_A];
   assign reg_b_o  = regs_q[IDX_B];
   assign reg_s_o  = regs_q[IDX_S];

endmodule

// File: rtl/regswap_chk.sv
module regswap_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [2:0]        drv_en_o,
   input logic [2:0]        ld_en_o,
   input logic              done_o,
   input logic [DATA_W-1:0] bus_o,
   input logic [DATA_W-1:0] reg_a_o,
   input logic [DATA_W-1:0] reg_s_o
);

   // R8: one source and one sink at most
   p_single_drv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drv_en_o) && $onehot0(ld_en_o));

   // R8: transfers always pair a source with a sink
   p_paired_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(drv_en_o) == $countones(ld_en_o));

   // R2
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en_o == 3'b000 && !start_i) |=> (drv_en_o == 3'b000 && !done_o));

   // R3
   p_start_save_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en_o == 3'b000 && start_i) |=> (drv_en_o == 3'b010 && ld_en_o == 3'b100));

   // R4
   p_save_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en_o == 3'b010) |=> (drv_en_o == 3'b001 && ld_en_o == 3'b010));

   // R5
   p_move_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en_o == 3'b001) |=> (done_o && drv_en_o == 3'b100 && ld_en_o == 3'b001));

   // R6, R9
   p_restore_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (drv_en_o == 3'b000 && ld_en_o == 3'b000 && !done_o));

   // R7: restore writes the scratch value into A
   p_restore_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (reg_a_o == $past(reg_s_o)));

   // R12
   p_idle_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en_o == 3'b000) |-> (bus_o == '0));

endmodule

bind regswap_unit regswap_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .drv_en_o (drv_en_o),
   .ld_en_o  (ld_en_o),
   .done_o   (done_o),
   .bus_o    (bus_o),
   .reg_a_o  (reg_a_o),
   .reg_s_o  (reg_s_o)
);

// File: tb/regswap_unit_tb.sv
`timescale 1ns/1ps
module regswap_unit_tb_top;

   localparam int unsigned DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [2:0]    wr_en_i = 3'b000;
   logic [DW-1:0] wr_data_i = '0;
   logic [2:0]    drv_en_o, ld_en_o;
   logic          done_o;
   logic [DW-1:0] bus_o, reg_a_o, reg_b_o, reg_s_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   regswap_unit #(.DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .drv_en_o(drv_en_o), .ld_en_o(ld_en_o), .done_o(done_o),
      .bus_o(bus_o), .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .reg_s_o(reg_s_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_step(input string req, input logic [2:0] d, input logic [2:0] l, input logic dn);
      chk({req, " drive"}, 32'(drv_en_o), 32'(d));
      chk({req, " load"},  32'(ld_en_o),  32'(l));
      chk({req, " done"},  32'(done_o),   32'(dn));
   endtask

   // R10: external preload, all three at once through separate edges
   task automatic preload(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] s);
      @(negedge clk); wr_en_i = 3'b001; wr_data_i = a;
      @(negedge clk); wr_en_i = 3'b010; wr_data_i = b;
      @(negedge clk); wr_en_i = 3'b100; wr_data_i = s;
      @(negedge clk); wr_en_i = 3'b000;
   endtask

   task automatic t_reset();
      chk_step("R1 reset", 3'b000, 3'b000, 1'b0);
      chk("R1 reg A", 32'(reg_a_o), 0);
      chk("R1 reg B", 32'(reg_b_o), 0);
      chk("R1 reg S", 32'(reg_s_o), 0);
   endtask

   task automatic t_idle();
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk_step("R2 idle hold", 3'b000, 3'b000, 1'b0);
      end
   endtask

   task automatic t_ext_write();
      preload(8'h11, 8'h22, 8'h33);
      chk("R10 write A", 32'(reg_a_o), 32'h11);
      chk("R10 write B", 32'(reg_b_o), 32'h22);
      chk("R10 write S", 32'(reg_s_o), 32'h33);
      wr_en_i = 3'b111; wr_data_i = 8'h44;
      @(negedge clk); wr_en_i = 3'b000;
      chk("R10 multi write A", 32'(reg_a_o), 32'h44);
      chk("R10 multi write S", 32'(reg_s_o), 32'h44);
   endtask

   task automatic t_swap(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic [DW-1:0] s);
      preload(a, b, s);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk_step("R3 save step", 3'b010, 3'b100, 1'b0);
      chk("R12 bus in save", 32'(bus_o), 32'(b));
      @(negedge clk);
      chk_step("R4 move step", 3'b001, 3'b010, 1'b0);
      chk("R7 scratch holds B", 32'(reg_s_o), 32'(b));
      chk("R12 bus in move", 32'(bus_o), 32'(a));
      @(negedge clk);
      chk_step("R5 restore step", 3'b100, 3'b001, 1'b1);
      chk("R12 bus in restore", 32'(bus_o), 32'(b));
      @(negedge clk);
      chk_step("R6 back to idle", 3'b000, 3'b000, 1'b0);
      chk("R7 A gets old B", 32'(reg_a_o), 32'(b));
      chk("R7 B gets old A", 32'(reg_b_o), 32'(a));
      chk("R7 S keeps old B", 32'(reg_s_o), 32'(b));
      chk("R12 idle bus", 32'(bus_o), 0);
   endtask

   task automatic t_retrigger();
      preload(8'h01, 8'h02, 8'h03);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      @(negedge clk); start_i = 1'b1;      // pulse inside the move step
      chk_step("R9 move step", 3'b001, 3'b010, 1'b0);
      @(negedge clk); start_i = 1'b0;
      chk_step("R9 restore unchanged", 3'b100, 3'b001, 1'b1);
      @(negedge clk);
      chk_step("R9 idle after", 3'b000, 3'b000, 1'b0);
      @(negedge clk);
      chk_step("R9 stays idle", 3'b000, 3'b000, 1'b0);
      chk("R9 single swap A", 32'(reg_a_o), 32'h02);
      chk("R9 single swap B", 32'(reg_b_o), 32'h01);
   endtask

   task automatic t_held_start();
      start_i = 1'b1;
      @(negedge clk); chk_step("R6 held save", 3'b010, 3'b100, 1'b0);
      @(negedge clk); chk_step("R6 held move", 3'b001, 3'b010, 1'b0);
      @(negedge clk); chk_step("R6 held restore", 3'b100, 3'b001, 1'b1);
      @(negedge clk); chk_step("R6 held idle gap", 3'b000, 3'b000, 1'b0);
      @(negedge clk); chk_step("R6 held restart", 3'b010, 3'b100, 1'b0);
      start_i = 1'b0;
      @(negedge clk); @(negedge clk); @(negedge clk);
      chk_step("R6 drained", 3'b000, 3'b000, 1'b0);
   endtask

   task automatic t_collision();
      preload(8'hA5, 8'h3C, 8'h00);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;       // now in save step
      wr_en_i = 3'b101; wr_data_i = 8'hEE;
      @(negedge clk); wr_en_i = 3'b000;     // now in move step
      chk("R11 bus beats write on S", 32'(reg_s_o), 32'h3C);
      chk("R11 other write lands on A", 32'(reg_a_o), 32'hEE);
      @(negedge clk); @(negedge clk);
      chk("R11 A after swap", 32'(reg_a_o), 32'h3C);
      chk("R11 B after swap", 32'(reg_b_o), 32'hEE);
   endtask

   initial begin
      #(8 * 5000);
      if (!finished) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_idle();
      t_ext_write();
      t_swap(8'h5A, 8'hC3, 8'h77);
      t_swap(8'hFF, 8'h00, 8'h81);
      t_retrigger();
      t_held_start();
      t_collision();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule